// File: doc/BRIEF.md
# Message-Driven Shared Interrupt Pending Register Unit

This unit holds the pending state of the shared peripheral interrupts in an interrupt distributor and lets devices raise or lower one of them by a single register write that carries the interrupt number, not a bit mask. Four write-only registers are provided: set and clear variants for non-secure use, and set and clear variants reserved for secure use. A per-interrupt group bit and a two-bit non-secure access level decide whether a non-secure write to a secure-group interrupt may act. A global security-disable input relaxes those checks. A write that fails any check is dropped without any response.

The unit also answers reads of a type register that reports support for message-driven interrupts and the number of 32-line groups implemented. The pending bits are presented as a flat vector to downstream arbitration logic. The group and access attributes are loaded through a separate configuration port.

Each write is classified by the decoder into one of five operations: none, non-secure set, non-secure clear, secure set, secure clear. An enumerated operation selects the acceptance rule. There is no multi-cycle sequencing. An accepted write updates the addressed pending bit at the next clock edge.

Top module: `msgirq_unit`

## Requirements
- R1: A write to byte offset 0x040 (non-secure set) takes the interrupt number from wr_data[9:0], ignores wr_data[31:10], and, when accepted, sets pend_vec[number] at the next clock edge.
- R2: A write to byte offset 0x048 (non-secure clear), when accepted, clears pend_vec[number] at the next clock edge.
- R3: A write whose number is below 32 or at or above NUM_LINES changes no pending bit.
- R4: A set write to an interrupt that is already pending, and a clear write to an interrupt that is not pending, change no pending bit.
- R5: A non-secure write (wr_secure=0) to the non-secure set register that targets a secure-group interrupt (group bit 0) is dropped when that interrupt's access level is 0. It is accepted when the level is 1, 2 or 3.
- R6: A non-secure write to the non-secure clear register that targets a secure-group interrupt is dropped when the access level is 0 or 1. It is accepted when the level is 2 or 3.
- R7: Writes to byte offsets 0x050 (secure set) and 0x058 (secure clear) act only when wr_secure=1 and sec_disable=0. Otherwise they are dropped.
- R8: While sec_disable=1, the non-secure set and clear registers act on any valid interrupt, with no group or access-level check.
- R9: Non-secure-group interrupts (group bit 1), and any write with wr_secure=1, pass the permission check of the non-secure registers whatever the access level.
- R10: Reading offset 0x004 returns the type word: bit 16 = 1, bit 17 = 1, bits [4:0] = ceil(NUM_LINES/32)-1, all other bits 0. Reads of 0x040, 0x048, 0x050 and 0x058 return 0.
- R11: Reset clears every pending bit and sets every group bit and access level to 0. A configuration write (cfg_valid=1) stores cfg_grp and cfg_nsacc for interrupt cfg_id at the next clock edge.
- R12: A cycle with no accepted write leaves pend_vec unchanged, and bits 0 to 31 of pend_vec are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_disable | input | 1 | Security-disable control: 1 treats all accesses as secure-capable |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data, interrupt number in bits [9:0] |
| wr_secure | input | 1 | 1 for a secure access |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cfg_valid | input | 1 | Attribute load strobe |
| cfg_id | input | 10 | Interrupt number whose attributes are loaded |
| cfg_grp | input | 1 | Group bit: 1 non-secure group, 0 secure group |
| cfg_nsacc | input | 2 | Non-secure access level |
| pend_vec | output | NUM_LINES | Pending bit per interrupt number |

## Verification
The bench walks the non-secure access level through 0 to 3 on a secure-group interrupt. This separates the set threshold (nonzero) from the clear threshold (two or more). A design that swapped or shared the thresholds would let a level-1 clear through, or would block a level-1 set. The bench fires numbers just outside the valid range (31, NUM_LINES, 1023) and writes with junk in the upper data bits. A design with an off-by-one range check or a wider number field would set a stray bit or aim at the wrong bit. Secure registers are hit with non-secure accesses and with security disabled. The non-secure registers are hit with security disabled and access level 0. A design that mixed up the two overrides would let a dropped write through, or would drop an allowed one.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_NS,
        OP_CLR_NS,
        OP_SET_S,
        OP_CLR_S
    } msg_op_e;

    localparam logic [11:0] OFF_TYPE   = 12'h004;
    localparam logic [11:0] OFF_SET_NS = 12'h040;
    localparam logic [11:0] OFF_CLR_NS = 12'h048;
    localparam logic [11:0] OFF_SET_S  = 12'h050;
    localparam logic [11:0] OFF_CLR_S  = 12'h058;

    localparam int FIRST_SHARED = 32;

endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode
    import msgirq_pkg::*;
(
    input  logic        wr_valid,
    input  logic [11:0] wr_addr,
    output msg_op_e     op
);

    always_comb begin
        op = OP_NONE;
        if (wr_valid) begin
            unique case (wr_addr)
                OFF_SET_NS: op = OP_SET_NS;
                OFF_CLR_NS: op = OP_CLR_NS;
                OFF_SET_S:  op = OP_SET_S;
                OFF_CLR_S:  op = OP_CLR_S;
                default:    op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/msgirq_cfg.sv
module msgirq_cfg #(
    parameter int NUM_LINES = 96,
    parameter int ID_W      = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid,
    input  logic [ID_W-1:0] cfg_id,
    input  logic            cfg_grp,
    input  logic [1:0]      cfg_nsacc,
    input  logic [ID_W-1:0] look_id,
    output logic            look_grp,
    output logic [1:0]      look_nsacc
);

    logic [NUM_LINES-1:0] grp_q;
    logic [1:0]           acc_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_attr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_q[i] <= 1'b0;
                acc_q[i] <= 2'd0;
            end else if (cfg_valid && (cfg_id == ID_W'(i))) begin
                grp_q[i] <= cfg_grp;
                acc_q[i] <= cfg_nsacc;
            end
        end
    end

    always_comb begin
        look_grp   = 1'b0;
        look_nsacc = 2'd0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (look_id == ID_W'(i)) begin
                look_grp   = grp_q[i];
                look_nsacc = acc_q[i];
            end
        end
    end

endmodule

// File: rtl/msgirq_gate.sv
module msgirq_gate
    import msgirq_pkg::*;
#(
    parameter int NUM_LINES = 96,
    parameter int ID_W      = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  msg_op_e         op,
    input  logic [ID_W-1:0] id,
    input  logic            wr_secure,
    input  logic            sec_disable,
    input  logic            pend_bit,
    input  logic            grp_bit,
    input  logic [1:0]      nsacc,
    output logic            acc_set,
    output logic            acc_clr
);

    localparam logic [ID_W-1:0] ID_LO = ID_W'(FIRST_SHARED);
    localparam logic [ID_W-1:0] ID_HI = ID_W'(NUM_LINES);

    logic id_ok;
    logic ns_to_sec;
    logic sec_path_ok;

    assign id_ok       = (id >= ID_LO) && (id < ID_HI);
    assign ns_to_sec   = !wr_secure && !grp_bit && !sec_disable;
    assign sec_path_ok = wr_secure && !sec_disable;

    always_comb begin
        acc_set = 1'b0;
        acc_clr = 1'b0;
        unique case (op)
            OP_SET_NS: acc_set = id_ok && !pend_bit && !(ns_to_sec && (nsacc == 2'd0));
            OP_CLR_NS: acc_clr = id_ok &&  pend_bit && !(ns_to_sec && (nsacc < 2'd2));
            OP_SET_S:  acc_set = id_ok && !pend_bit && sec_path_ok;
            OP_CLR_S:  acc_clr = id_ok &&  pend_bit && sec_path_ok;
            default: begin
                acc_set = 1'b0;
                acc_clr = 1'b0;
            end
        endcase
    end

    assert_set_clr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_set && acc_clr));

    assert_idle_no_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |-> (!acc_set && !acc_clr));

    assert_sec_regs_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (((op == OP_SET_S) || (op == OP_CLR_S)) && (sec_disable || !wr_secure))
            |-> (!acc_set && !acc_clr));

endmodule

// File: rtl/msgirq_unit.sv
module msgirq_unit
    import msgirq_pkg::*;
#(
    parameter int NUM_LINES = 96
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_disable,
    input  logic                 wr_valid,
    input  logic [11:0]          wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 wr_secure,
    input  logic [11:0]          rd_addr,
    output logic [31:0]          rd_data,
    input  logic                 cfg_valid,
    input  logic [9:0]           cfg_id,
    input  logic                 cfg_grp,
    input  logic [1:0]           cfg_nsacc,
    output logic [NUM_LINES-1:0] pend_vec
);

    localparam int ID_W   = 10;
    localparam int GRP_M1 = (NUM_LINES + 31) / 32 - 1;
    localparam logic [31:0] TYPE_WORD = (32'd1 << 17) | (32'd1 << 16) | 32'(GRP_M1 & 31);

    msg_op_e              op;
    logic [ID_W-1:0]      id;
    logic                 pend_bit;
    logic                 grp_bit;
    logic [1:0]           nsacc;
    logic                 acc_set;
    logic                 acc_clr;
    logic [NUM_LINES-1:0] pend_q;

    assign id = wr_data[ID_W-1:0];

    msgirq_decode u_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .op       (op)
    );

    msgirq_cfg #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_id     (cfg_id),
        .cfg_grp    (cfg_grp),
        .cfg_nsacc  (cfg_nsacc),
        .look_id    (id),
        .look_grp   (grp_bit),
        .look_nsacc (nsacc)
    );

    msgirq_gate #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .id          (id),
        .wr_secure   (wr_secure),
        .sec_disable (sec_disable),
        .pend_bit    (pend_bit),
        .grp_bit     (grp_bit),
        .nsacc       (nsacc),
        .acc_set     (acc_set),
        .acc_clr     (acc_clr)
    );

    always_comb begin
        pend_bit = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (id == ID_W'(i)) pend_bit = pend_q[i];
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (id == ID_W'(i)) begin
                if (acc_set)      pend_q[i] <= 1'b1;
                else if (acc_clr) pend_q[i] <= 1'b0;
            end
        end
    end

    assign pend_vec = pend_q;

    always_comb begin
        unique case (rd_addr)
            OFF_TYPE: rd_data = TYPE_WORD;
            default:  rd_data = 32'd0;
        endcase
    end

    assert_set_adds_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_set |=> ($countones(pend_q) == $past($countones(pend_q)) + 1));

    assert_clr_drops_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));

    assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_set && !acc_clr) |=> $stable(pend_q));

    assert_low_ids_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[FIRST_SHARED-1:0] == '0);

endmodule

// File: tb/msgirq_unit_tb.sv
module msgirq_unit_tb;

    localparam int N = 96;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sec_disable;
    logic         wr_valid;
    logic [11:0]  wr_addr;
    logic [31:0]  wr_data;
    logic         wr_secure;
    logic [11:0]  rd_addr;
    logic [31:0]  rd_data;
    logic         cfg_valid;
    logic [9:0]   cfg_id;
    logic         cfg_grp;
    logic [1:0]   cfg_nsacc;
    logic [N-1:0] pend_vec;

    logic [N-1:0] exp_vec;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    msgirq_unit #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_secure(wr_secure), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_valid(cfg_valid), .cfg_id(cfg_id), .cfg_grp(cfg_grp),
        .cfg_nsacc(cfg_nsacc), .pend_vec(pend_vec)
    );

    task automatic check_vec(string req);
        total++;
        if (pend_vec !== exp_vec) begin
            bad++;
            $display("FAIL %s: pend_vec=%h expected=%h", req, pend_vec, exp_vec);
        end
    endtask

    task automatic check_word(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d, logic sec);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_secure = sec;
        @(negedge clk);
        wr_valid = 1'b0; wr_data = 32'd0;
    endtask

    task automatic do_cfg(logic [9:0] id, logic grp, logic [1:0] lvl);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_id = id; cfg_grp = grp; cfg_nsacc = lvl;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic t_reset;
        exp_vec = '0;
        check_vec("R11 reset");
        rd_addr = 12'h004; #1;
        check_word("R10 type word", rd_data, 32'h0003_0002);
    endtask

    task automatic t_basic;
        do_write(12'h040, 32'hFFFF_FC00 | 32'd40, 1'b1);
        exp_vec[40] = 1'b1;
        check_vec("R1 set with junk upper bits");
        do_write(12'h040, 32'd95, 1'b1);
        exp_vec[95] = 1'b1;
        check_vec("R1 set top line");
        do_write(12'h048, 32'hABCD_0000 | 32'd40, 1'b1);
        exp_vec[40] = 1'b0;
        check_vec("R2 clear");
        do_write(12'h048, 32'd32, 1'b1);
        check_vec("R4 clear of idle line");
    endtask

    task automatic t_invalid;
        do_write(12'h040, 32'd31, 1'b1);
        check_vec("R3 id 31");
        do_write(12'h040, 32'd96, 1'b1);
        check_vec("R3 id NUM_LINES");
        do_write(12'h050, 32'd1023, 1'b1);
        check_vec("R3 id 1023");
        do_write(12'h044, 32'd33, 1'b1);
        check_vec("R12 unmapped offset");
    endtask

    task automatic t_already;
        do_write(12'h040, 32'd50, 1'b1);
        exp_vec[50] = 1'b1;
        check_vec("R1 set 50");
        do_write(12'h040, 32'd50, 1'b1);
        check_vec("R4 set already pending");
        do_write(12'h048, 32'd50, 1'b1);
        exp_vec[50] = 1'b0;
        do_write(12'h048, 32'd50, 1'b1);
        check_vec("R4 clear not pending");
    endtask

    task automatic t_levels;
        do_cfg(10'd60, 1'b0, 2'd0);
        do_write(12'h040, 32'd60, 1'b0);
        check_vec("R5 level0 set dropped");
        do_cfg(10'd60, 1'b0, 2'd1);
        do_write(12'h040, 32'd60, 1'b0);
        exp_vec[60] = 1'b1;
        check_vec("R5 level1 set accepted");
        do_write(12'h048, 32'd60, 1'b0);
        check_vec("R6 level1 clear dropped");
        do_cfg(10'd60, 1'b0, 2'd2);
        do_write(12'h048, 32'd60, 1'b0);
        exp_vec[60] = 1'b0;
        check_vec("R6 level2 clear accepted");
        do_cfg(10'd60, 1'b0, 2'd3);
        do_write(12'h040, 32'd60, 1'b0);
        do_write(12'h048, 32'd60, 1'b0);
        check_vec("R6 level3 set then clear");
    endtask

    task automatic t_nsgroup;
        do_cfg(10'd70, 1'b1, 2'd0);
        do_write(12'h040, 32'd70, 1'b0);
        exp_vec[70] = 1'b1;
        check_vec("R9 ns group set level0");
        do_write(12'h048, 32'd70, 1'b0);
        exp_vec[70] = 1'b0;
        check_vec("R9 ns group clear level0");
        do_write(12'h040, 32'd71, 1'b1);
        exp_vec[71] = 1'b1;
        check_vec("R9 secure access on ns regs");
    endtask

    task automatic t_secregs;
        do_write(12'h050, 32'd80, 1'b0);
        check_vec("R7 ns access to secure set");
        do_write(12'h050, 32'd80, 1'b1);
        exp_vec[80] = 1'b1;
        check_vec("R7 secure set");
        do_write(12'h058, 32'd80, 1'b0);
        check_vec("R7 ns access to secure clear");
        sec_disable = 1'b1;
        do_write(12'h058, 32'd80, 1'b1);
        check_vec("R7 secure clear with disable");
        do_write(12'h050, 32'd81, 1'b1);
        check_vec("R7 secure set with disable");
        sec_disable = 1'b0;
        do_write(12'h058, 32'd80, 1'b1);
        exp_vec[80] = 1'b0;
        check_vec("R7 secure clear");
    endtask

    task automatic t_disable;
        do_cfg(10'd60, 1'b0, 2'd0);
        sec_disable = 1'b1;
        do_write(12'h040, 32'd60, 1'b0);
        exp_vec[60] = 1'b1;
        check_vec("R8 set without check");
        do_write(12'h048, 32'd60, 1'b0);
        exp_vec[60] = 1'b0;
        check_vec("R8 clear without check");
        sec_disable = 1'b0;
    endtask

    task automatic t_reads;
        foreach (exp_vec[k]) begin end
        for (int k = 0; k < 4; k++) begin
            rd_addr = 12'h040 + 12'(8 * k); #1;
            check_word("R10 message reg reads zero", rd_data, 32'd0);
        end
    endtask

    task automatic t_midreset;
        do_write(12'h040, 32'd33, 1'b1);
        exp_vec[33] = 1'b1;
        check_vec("R1 set 33");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_vec = '0;
        check_vec("R11 reset clears pending");
        do_write(12'h040, 32'd60, 1'b0);
        check_vec("R11 reset clears access level");
    endtask

    initial begin
        rst_n = 1'b0; sec_disable = 1'b0;
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_secure = 1'b0;
        rd_addr = '0; cfg_valid = 1'b0; cfg_id = '0; cfg_grp = 1'b0; cfg_nsacc = '0;
        exp_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_invalid;
        t_already;
        t_levels;
        t_nsgroup;
        t_secregs;
        t_disable;
        t_reads;
        t_midreset;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule